// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Pending-Record Queue

This block keeps the logging state for uncorrectable errors of one link function. It holds the uncorrectable status register (cleared by writing ones), a pointer to the first error still being reported, a four-dword header log and a four-dword prefix log. When multi-header recording is switched on, any error that arrives while the first error is still set is held in a small first-in first-out record queue. It is not written to the log registers at that time.

Software works through pending errors one at a time. Each time it clears the status bit the pointer selects, the oldest queued record moves into the log registers. The status bits of all queued records are set again, so software cannot clear them early. A record that finds the queue full is dropped and raises a one-cycle overflow pulse. Classifying errors and routing messages happen elsewhere. Only one event is accepted per cycle.

Top module: `uerr_hdr_log`

## Requirements
- R1: After reset, status, pointer, both logs, the prefix flag, the recording enable and the overflow output are all zero.
- R2: A record that is not queued loads the pointer with the bit index of the lowest set bit of its status word, and sets that bit in the status register.
- R3: A loaded record with header-valid set places input dword i (bits 32i+31..32i) into the header log at the same dword with its four bytes reversed. With header-valid clear, the header log becomes zero.
- R4: The prefix log is loaded (with the same per-dword byte reversal) and the prefix flag set only when the record carries a prefix and `pfx_supported` is high. Otherwise the prefix log and the flag are cleared.
- R5: With recording enabled and the status bit at the pointer still set, a new record goes into the queue. The pointer and logs stay unchanged, and the record's status bit is still set.
- R6: A record that would be queued while the queue holds the clamped depth of entries is dropped, and `overflow` is high for exactly the next cycle.
- R7: A status write that clears the pointed-to bit, with recording enabled and the queue non-empty, removes the oldest queued record into the pointer and logs. It also ORs the status bits of every queued record (including that one) back into the status register.
- R8: A status write that clears the pointed-to bit in any other case clears the pointer, the prefix flag and both logs.
- R9: A status write that leaves the pointed-to bit set, with recording enabled, re-sets the status bits of all queued records.
- R10: Disabling recording through a control write, or a status write that leaves the pointed-to bit set while recording is off, empties the queue.
- R11: The queue depth is `DEPTH` clamped to `MAX_DEPTH`. `mhr_capable` is high only when the clamped depth is above zero, and the enable can be set only when it is capable.
- R12: Only one event is taken per cycle, with priority record, then status write, then control write; a losing write in the same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_valid | input | 1 | Record request this cycle |
| rec_status | input | 32 | One-hot uncorrectable status of the record |
| rec_hdr_valid | input | 1 | Record carries a valid header |
| rec_pfx_present | input | 1 | Record carries a prefix |
| rec_hdr | input | 128 | Header dwords, dword 0 in bits 31..0 |
| rec_pfx | input | 128 | Prefix dwords, dword 0 in bits 31..0 |
| pfx_supported | input | 1 | End-to-end prefix logging is supported |
| sts_wr_en | input | 1 | Write to the status register |
| sts_wr_data | input | 32 | Ones clear the matching status bits |
| ctl_wr_en | input | 1 | Write to the control register |
| ctl_wr_mhr_en | input | 1 | New value of the recording enable |
| uc_status | output | 32 | Uncorrectable status register |
| first_ptr | output | 5 | First-error pointer |
| pfx_logged | output | 1 | Prefix log holds a prefix |
| hdr_log | output | 128 | Header log |
| pfx_log | output | 128 | Prefix log |
| mhr_capable | output | 1 | Multi-header recording is available |
| mhr_en | output | 1 | Multi-header recording is enabled |
| overflow | output | 1 | One-cycle pulse for a dropped record |

## Verification
The properties assume that `rec_status` carries exactly one set bit whenever `rec_valid` is high. Under that assumption the pointer and the pointed-to status bit describe the same error. The stimulus therefore builds every record status as a single shifted one. Same-cycle collisions are driven only on purpose, to exercise the priority rule. The queue walk uses distinct bit positions, so that each popped record can be identified by its pointer and header.

// File: rtl/uerr_log_pkg.sv
package uerr_log_pkg;
  localparam int ERR_W = 32;
  localparam int DW_N  = 4;
  localparam int LOG_W = 32 * DW_N;
  localparam int PTR_W = $clog2(ERR_W);

  typedef struct packed {
    logic [ERR_W-1:0] status;
    logic             hdr_v;
    logic             pfx_p;
    logic [LOG_W-1:0] hdr;
    logic [LOG_W-1:0] pfx;
  } uerr_rec_t;

  // index of the lowest set bit (trailing-zero count)
  function automatic logic [PTR_W-1:0] lsb_index(input logic [ERR_W-1:0] v);
    lsb_index = '0;
    for (int i = ERR_W - 1; i >= 0; i--)
      if (v[i]) lsb_index = PTR_W'(i);
  endfunction

  // reverse the byte order inside every dword
  function automatic logic [LOG_W-1:0] dword_bswap(input logic [LOG_W-1:0] v);
    dword_bswap = '0;
    for (int w = 0; w < DW_N; w++)
      for (int b = 0; b < 4; b++)
        dword_bswap[32*w + 8*b +: 8] = v[32*w + 8*(3-b) +: 8];
  endfunction
endpackage

// File: rtl/uerr_log_fmt.sv
module uerr_log_fmt
  import uerr_log_pkg::*;
(
  input  uerr_rec_t        rec,
  input  logic             pfx_supported,
  output logic [PTR_W-1:0] ptr,
  output logic [LOG_W-1:0] hdr_log,
  output logic [LOG_W-1:0] pfx_log,
  output logic             pfx_flag
);
  logic keep_pfx;
  assign keep_pfx = rec.pfx_p & pfx_supported;
  assign ptr      = lsb_index(rec.status);
  assign hdr_log  = rec.hdr_v ? dword_bswap(rec.hdr) : '0;
  assign pfx_log  = keep_pfx ? dword_bswap(rec.pfx) : '0;
  assign pfx_flag = keep_pfx;
endmodule

// File: rtl/uerr_rec_fifo.sv
module uerr_rec_fifo
  import uerr_log_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LIMIT = 4,
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  uerr_rec_t        push_rec,
  output uerr_rec_t        head_rec,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic [ERR_W-1:0] status_or
);
  uerr_rec_t     mem [SLOTS];
  logic [IW-1:0] head;
  logic [IW-1:0] tail;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] idx);
    step = (int'(idx) == SLOTS - 1) ? '0 : idx + IW'(1);
  endfunction

  always_comb begin
    int t;
    t = int'(head) + int'(count);
    if (t >= SLOTS) t = t - SLOTS;
    tail = IW'(t);
  end

  assign full     = (int'(count) >= LIMIT);
  assign head_rec = mem[head];

  always_comb begin
    status_or = '0;
    for (int i = 0; i < SLOTS; i++) begin
      int rel;
      rel = i - int'(head);
      if (rel < 0) rel = rel + SLOTS;
      if (rel < int'(count)) status_or = status_or | mem[i].status;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[tail] <= push_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else if (flush) begin
      count <= '0;
    end else if (push && !full) begin
      count <= count + CW'(1);
    end else if (pop && count != '0) begin
      head  <= step(head);
      count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/uerr_hdr_log.sv
module uerr_hdr_log
  import uerr_log_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int MAX_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_valid,
  input  logic [ERR_W-1:0] rec_status,
  input  logic             rec_hdr_valid,
  input  logic             rec_pfx_present,
  input  logic [LOG_W-1:0] rec_hdr,
  input  logic [LOG_W-1:0] rec_pfx,
  input  logic             pfx_supported,
  input  logic             sts_wr_en,
  input  logic [ERR_W-1:0] sts_wr_data,
  input  logic             ctl_wr_en,
  input  logic             ctl_wr_mhr_en,
  output logic [ERR_W-1:0] uc_status,
  output logic [PTR_W-1:0] first_ptr,
  output logic             pfx_logged,
  output logic [LOG_W-1:0] hdr_log,
  output logic [LOG_W-1:0] pfx_log,
  output logic             mhr_capable,
  output logic             mhr_en,
  output logic             overflow
);
  localparam int QD     = (DEPTH > MAX_DEPTH) ? MAX_DEPTH : ((DEPTH < 0) ? 0 : DEPTH);
  localparam int QSLOTS = (QD == 0) ? 1 : QD;
  localparam int CW     = $clog2(QSLOTS + 1);

  // named events
  logic rec_ev, sts_ev, ctl_ev;
  logic first_busy, queue_req, push_ev, drop_ev, load_ev;
  logic first_cleared, pop_ev, clear_log_ev, reassert_ev, flush_ev;
  logic [ERR_W-1:0] sts_next, q_status_or;
  logic [CW-1:0]    q_count;
  logic             q_full;

  uerr_rec_t in_rec, head_rec;
  logic [PTR_W-1:0] in_ptr, hd_ptr;
  logic [LOG_W-1:0] in_hdr, hd_hdr, in_pfx, hd_pfx;
  logic             in_pflag, hd_pflag;

  assign mhr_capable = (QD > 0);

  assign rec_ev = rec_valid;
  assign sts_ev = sts_wr_en & ~rec_valid;
  assign ctl_ev = ctl_wr_en & ~rec_valid & ~sts_wr_en;

  assign first_busy = uc_status[first_ptr];
  assign queue_req  = rec_ev & mhr_en & first_busy;
  assign push_ev    = queue_req & ~q_full;
  assign drop_ev    = queue_req & q_full;
  assign load_ev    = rec_ev & ~queue_req;

  assign sts_next      = uc_status & ~sts_wr_data;
  assign first_cleared = ~sts_next[first_ptr];
  assign pop_ev        = sts_ev & first_cleared & mhr_en & (q_count != '0);
  assign clear_log_ev  = sts_ev & first_cleared & ~pop_ev;
  assign reassert_ev   = sts_ev & ~first_cleared & mhr_en;
  assign flush_ev      = (sts_ev & ~first_cleared & ~mhr_en) | (ctl_ev & ~ctl_wr_mhr_en);

  assign in_rec = '{status: rec_status, hdr_v: rec_hdr_valid, pfx_p: rec_pfx_present,
                    hdr: rec_hdr, pfx: rec_pfx};

  uerr_log_fmt u_fmt_in (
    .rec(in_rec), .pfx_supported(pfx_supported),
    .ptr(in_ptr), .hdr_log(in_hdr), .pfx_log(in_pfx), .pfx_flag(in_pflag)
  );

  uerr_log_fmt u_fmt_head (
    .rec(head_rec), .pfx_supported(pfx_supported),
    .ptr(hd_ptr), .hdr_log(hd_hdr), .pfx_log(hd_pfx), .pfx_flag(hd_pflag)
  );

  uerr_rec_fifo #(.SLOTS(QSLOTS), .LIMIT(QD)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push_ev), .pop(pop_ev), .flush(flush_ev),
    .push_rec(in_rec), .head_rec(head_rec),
    .count(q_count), .full(q_full), .status_or(q_status_or)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uc_status  <= '0;
      first_ptr  <= '0;
      pfx_logged <= 1'b0;
      hdr_log    <= '0;
      pfx_log    <= '0;
      mhr_en     <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      overflow <= drop_ev;
      if (rec_ev) begin
        uc_status <= uc_status | rec_status;
      end else if (sts_ev) begin
        uc_status <= (pop_ev || reassert_ev) ? (sts_next | q_status_or) : sts_next;
      end
      if (ctl_ev) mhr_en <= ctl_wr_mhr_en & mhr_capable;
      if (load_ev) begin
        first_ptr  <= in_ptr;
        hdr_log    <= in_hdr;
        pfx_log    <= in_pfx;
        pfx_logged <= in_pflag;
      end else if (pop_ev) begin
        first_ptr  <= hd_ptr;
        hdr_log    <= hd_hdr;
        pfx_log    <= hd_pfx;
        pfx_logged <= hd_pflag;
      end else if (clear_log_ev) begin
        first_ptr  <= '0;
        hdr_log    <= '0;
        pfx_log    <= '0;
        pfx_logged <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uerr_log_chk.sv
module uerr_log_chk
  import uerr_log_pkg::*;
#(
  parameter int QD = 4,
  parameter int CW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             overflow,
  input logic             q_full,
  input logic [CW-1:0]    q_count,
  input logic             pop_ev,
  input logic             flush_ev,
  input logic             load_ev,
  input logic [ERR_W-1:0] uc_status,
  input logic [PTR_W-1:0] first_ptr,
  input logic             mhr_en,
  input logic             mhr_capable
);
  AST_LOAD_SETS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> uc_status[first_ptr]); // R2

  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(q_full)); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_count) <= QD); // R6

  AST_POP_KEEPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> uc_status[first_ptr]); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ev |=> q_count == '0); // R10

  AST_EN_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    mhr_en |-> mhr_capable); // R11

  AST_CAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mhr_capable)); // R11
endmodule

bind uerr_hdr_log uerr_log_chk #(.QD(QD), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .overflow(overflow), .q_full(q_full),
  .q_count(q_count), .pop_ev(pop_ev), .flush_ev(flush_ev), .load_ev(load_ev),
  .uc_status(uc_status), .first_ptr(first_ptr), .mhr_en(mhr_en),
  .mhr_capable(mhr_capable)
);

// File: tb/sim_uerr_hdr_log.sv
module sim_uerr_hdr_log;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rec_valid = 1'b0;
  logic [31:0]  rec_status = '0;
  logic         rec_hdr_valid = 1'b0;
  logic         rec_pfx_present = 1'b0;
  logic [127:0] rec_hdr = '0;
  logic [127:0] rec_pfx = '0;
  logic         pfx_supported = 1'b0;
  logic         sts_wr_en = 1'b0;
  logic [31:0]  sts_wr_data = '0;
  logic         ctl_wr_en = 1'b0;
  logic         ctl_wr_mhr_en = 1'b0;

  logic [31:0]  st0, st1, st2;
  logic [4:0]   fp0, fp1, fp2;
  logic         pl0, pl1, pl2, cap0, cap1, cap2, en0, en1, en2, ov0, ov1, ov2;
  logic [127:0] hl0, hl1, hl2, pf0, pf1, pf2;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  uerr_hdr_log #(.DEPTH(4), .MAX_DEPTH(16)) u0 (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_status(rec_status),
    .rec_hdr_valid(rec_hdr_valid), .rec_pfx_present(rec_pfx_present),
    .rec_hdr(rec_hdr), .rec_pfx(rec_pfx), .pfx_supported(pfx_supported),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .ctl_wr_en(ctl_wr_en),
    .ctl_wr_mhr_en(ctl_wr_mhr_en), .uc_status(st0), .first_ptr(fp0),
    .pfx_logged(pl0), .hdr_log(hl0), .pfx_log(pf0), .mhr_capable(cap0),
    .mhr_en(en0), .overflow(ov0));

  uerr_hdr_log #(.DEPTH(0), .MAX_DEPTH(16)) u1 (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_status(rec_status),
    .rec_hdr_valid(rec_hdr_valid), .rec_pfx_present(rec_pfx_present),
    .rec_hdr(rec_hdr), .rec_pfx(rec_pfx), .pfx_supported(pfx_supported),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .ctl_wr_en(ctl_wr_en),
    .ctl_wr_mhr_en(ctl_wr_mhr_en), .uc_status(st1), .first_ptr(fp1),
    .pfx_logged(pl1), .hdr_log(hl1), .pfx_log(pf1), .mhr_capable(cap1),
    .mhr_en(en1), .overflow(ov1));

  uerr_hdr_log #(.DEPTH(5), .MAX_DEPTH(2)) u2 (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_status(rec_status),
    .rec_hdr_valid(rec_hdr_valid), .rec_pfx_present(rec_pfx_present),
    .rec_hdr(rec_hdr), .rec_pfx(rec_pfx), .pfx_supported(pfx_supported),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .ctl_wr_en(ctl_wr_en),
    .ctl_wr_mhr_en(ctl_wr_mhr_en), .uc_status(st2), .first_ptr(fp2),
    .pfx_logged(pl2), .hdr_log(hl2), .pfx_log(pf2), .mhr_capable(cap2),
    .mhr_en(en2), .overflow(ov2));

  function automatic logic [127:0] mk_words(input int k, input int salt);
    logic [127:0] r;
    for (int i = 0; i < 4; i++)
      r[32*i +: 32] = {8'(k), 8'(i + salt), 8'hA5, 8'(k + 3*i + 1)};
    return r;
  endfunction

  function automatic logic [127:0] swapped(input logic [127:0] v);
    logic [31:0] d;
    logic [127:0] r;
    for (int i = 0; i < 4; i++) begin
      d = v[32*i +: 32];
      r[32*i +: 32] = {d[7:0], d[15:8], d[23:16], d[31:24]};
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rec_valid = 1'b0; sts_wr_en = 1'b0; ctl_wr_en = 1'b0;
  endtask

  task automatic do_rec(input int bitpos, input logic hv, input logic pp, input int k);
    @(negedge clk);
    rec_valid = 1'b1; rec_status = 32'h1 << bitpos;
    rec_hdr_valid = hv; rec_pfx_present = pp;
    rec_hdr = mk_words(k, 0); rec_pfx = mk_words(k, 7);
    @(negedge clk);
    idle();
  endtask

  task automatic do_sts(input logic [31:0] d);
    @(negedge clk);
    sts_wr_en = 1'b1; sts_wr_data = d;
    @(negedge clk);
    idle();
  endtask

  task automatic do_ctl(input logic v);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_mhr_en = v;
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", 128'(st0), 128'h0);
    chk("R1 ptr", 128'(fp0), 128'h0);
    chk("R1 hdr", hl0, 128'h0);
    chk("R1 pfx", pf0, 128'h0);
    chk("R1 flags", {pl0, en0, ov0}, 128'h0);

    // R2 R3 R4 sweep of every status bit, no queueing
    for (int k = 0; k < 32; k++) begin
      logic hv, pp, ps;
      hv = ~k[2]; pp = k[0]; ps = k[1];
      pfx_supported = ps;
      do_rec(k, hv, pp, k);
      chk("R2 ptr", 128'(fp0), 128'(k));
      chk("R2 status", 128'(st0), 128'(32'h1 << k));
      chk("R3 hdr", hl0, hv ? swapped(mk_words(k, 0)) : 128'h0);
      chk("R4 pfx", pf0, (pp && ps) ? swapped(mk_words(k, 7)) : 128'h0);
      chk("R4 flag", 128'(pl0), 128'(pp && ps));
      do_sts(32'h1 << k);
      chk("R8 status", 128'(st0), 128'h0);
      chk("R8 logs", {hl0 | pf0}, 128'h0);
      chk("R8 ptr flag", 128'({fp0, pl0}), 128'h0);
    end

    // R12 record wins over a status write in the same cycle
    pfx_supported = 1'b1;
    do_rec(4, 1'b1, 1'b0, 40);
    @(negedge clk);
    rec_valid = 1'b1; rec_status = 32'h1 << 6; rec_hdr = mk_words(41, 0);
    rec_hdr_valid = 1'b1; rec_pfx_present = 1'b0;
    sts_wr_en = 1'b1; sts_wr_data = 32'h1 << 4;
    @(negedge clk);
    idle();
    chk("R12 write ignored", 128'(st0), 128'((32'h1 << 4) | (32'h1 << 6)));
    chk("R12 ptr", 128'(fp0), 128'd6);
    // status write wins over control write
    @(negedge clk);
    sts_wr_en = 1'b1; sts_wr_data = 32'h0; ctl_wr_en = 1'b1; ctl_wr_mhr_en = 1'b1;
    @(negedge clk);
    idle();
    chk("R12 ctl ignored", 128'(en0), 128'h0);
    do_sts(32'hFFFF_FFFF);
    chk("R8 full clear", 128'(st0), 128'h0);

    // R11 capability and enable
    chk("R11 cap u0", 128'(cap0), 128'h1);
    chk("R11 cap u1", 128'(cap1), 128'h0);
    chk("R11 cap u2", 128'(cap2), 128'h1);
    do_ctl(1'b1);
    chk("R11 en u0", 128'(en0), 128'h1);
    chk("R11 en u1", 128'(en1), 128'h0);

    // R5 R6 queue fill
    do_rec(3, 1'b1, 1'b0, 100);
    do_rec(7, 1'b1, 1'b1, 101);
    chk("R5 ptr held", 128'(fp0), 128'd3);
    chk("R5 hdr held", hl0, swapped(mk_words(100, 0)));
    chk("R5 bit set", 128'(st0), 128'((32'h1 << 3) | (32'h1 << 7)));
    do_rec(12, 1'b1, 1'b0, 102);
    do_rec(20, 1'b0, 1'b0, 103);
    chk("R6 clamp overflow u2", 128'(ov2), 128'h1);
    chk("R6 no overflow u0", 128'(ov0), 128'h0);
    do_rec(31, 1'b1, 1'b0, 104);
    chk("R6 fourth queued", 128'(ov0), 128'h0);
    do_rec(5, 1'b1, 1'b0, 105);
    chk("R6 overflow", 128'(ov0), 128'h1);
    @(negedge clk);
    chk("R6 pulse", 128'(ov0), 128'h0);
    chk("R6 dropped bit set", 128'(st0),
        128'(32'h8000_0000 | (32'h1 << 20) | (32'h1 << 12) | (32'h1 << 7) | (32'h1 << 5) | (32'h1 << 3)));

    // R9 reassert queued bits
    do_sts((32'h1 << 7) | (32'h1 << 5));
    chk("R9 reassert", 128'(st0),
        128'(32'h8000_0000 | (32'h1 << 20) | (32'h1 << 12) | (32'h1 << 7) | (32'h1 << 3)));
    chk("R9 ptr", 128'(fp0), 128'd3);

    // R7 pops in arrival order
    do_sts(32'h1 << 3);
    chk("R7 pop1 ptr", 128'(fp0), 128'd7);
    chk("R7 pop1 hdr", hl0, swapped(mk_words(101, 0)));
    chk("R7 pop1 pfx", pf0, swapped(mk_words(101, 7)));
    chk("R7 pop1 flag", 128'(pl0), 128'h1);
    chk("R7 pop1 status", 128'(st0),
        128'(32'h8000_0000 | (32'h1 << 20) | (32'h1 << 12) | (32'h1 << 7)));
    do_sts(32'h1 << 7);
    chk("R7 pop2 ptr", 128'(fp0), 128'd12);
    chk("R7 pop2 flag", 128'(pl0), 128'h0);
    do_sts(32'h1 << 12);
    chk("R7 pop3 ptr", 128'(fp0), 128'd20);
    chk("R7 pop3 hdr", hl0, 128'h0);
    do_sts(32'h1 << 20);
    chk("R7 pop4 ptr", 128'(fp0), 128'd31);
    chk("R7 pop4 hdr", hl0, swapped(mk_words(104, 0)));
    chk("R7 pop4 status", 128'(st0), 128'(32'h8000_0000));
    do_sts(32'h8000_0000);
    chk("R8 empty clear", {hl0 | pf0 | 128'({fp0, pl0})}, 128'h0);
    chk("R8 status", 128'(st0), 128'h0);

    // R10 disabling flushes the queue
    do_rec(2, 1'b1, 1'b0, 110);
    do_rec(9, 1'b1, 1'b0, 111);
    do_ctl(1'b0);
    chk("R10 disabled", 128'(en0), 128'h0);
    do_sts(32'h1 << 2);
    chk("R10 no pop ptr", 128'(fp0), 128'h0);
    chk("R10 no pop hdr", hl0, 128'h0);
    chk("R10 status", 128'(st0), 128'(32'h1 << 9));

    finish_run();
  end
endmodule